// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

This block collects interrupt requests from a configurable set of input pins and turns each accepted request into one interrupt message on a valid/ready output. Every pin owns a two-word redirection entry that sets the message vector, the 3-bit delivery mode and the 16-bit destination, plus a per-pin active-low polarity bit, an edge/level trigger bit and a mask bit.

Software reaches all entries through a small indirect window on a simple write bus. It writes an index into the index window, then reads or writes the selected word through the data window. A third bus address takes end-of-interrupt writes. A read-only version word at index 0x01 reports the version number and the highest pin index.

Edge pins latch a request on each inactive-to-active transition seen while unmasked; transitions that happen while masked are lost. Level pins deliver one message and then stay blocked until software writes their vector to the end-of-interrupt address, which re-arms every level pin carrying that vector. When several pins want the output at once, the lowest-numbered one goes first, and a message holds still until the receiver takes it.

Top module: `irq_redir_ctrl`

## Requirements
- R1: Reading the data window with index 0x01 returns a word with the version number in bits 7:0, the highest pin index (NUM_PINS-1) in bits 23:16 and zero in all other bits.
- R2: Bus address 0 is the index window (reads back the 8-bit index in bits 7:0), address 1 is the data window. The low word of entry n is at index 0x10+2n with vector in 7:0, delivery mode in 10:8, active-low polarity in bit 13, level trigger in bit 15 and mask in bit 16; the high word is at 0x11+2n with the destination in 31:16. All other bits read zero; data writes at an index outside the table change no entry and such indices read zero.
- R3: After reset every entry reads with only the mask bit (bit 16) set, and no message is offered.
- R4: An unmasked edge pin produces exactly one message per inactive-to-active transition, carrying the entry's vector, destination and delivery mode; holding the pin active produces no more.
- R5: With the polarity bit set, a pin is active when its input is low.
- R6: An edge transition that occurs while the pin is masked is discarded; clearing the mask afterwards produces no message.
- R7: A level pin (bit 15 set) that is active and unmasked delivers one message and then no more until its vector is written to bus address 2 (vector in bits 7:0); if still active then, it delivers again.
- R8: One end-of-interrupt write re-arms every level pin whose entry holds that vector; a write of a different vector re-arms none.
- R9: When several pins are requesting at the same time, the lowest-numbered pin's message is offered first.
- R10: While the message output is valid and not ready, valid and all message fields stay unchanged.
- R11: A masked active level pin delivers nothing; clearing its mask while the input is still active produces a message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pins_i | input | NUM_PINS | Interrupt request inputs, one per pin |
| reg_wr_en_i | input | 1 | Bus write strobe |
| reg_addr_i | input | 2 | Bus address: 0 index, 1 data, 2 end-of-interrupt |
| reg_wdata_i | input | 32 | Bus write data |
| reg_rdata_o | output | 32 | Bus read data for the addressed window |
| msg_valid_o | output | 1 | Interrupt message offered |
| msg_ready_i | input | 1 | Receiver takes the message |
| msg_vector_o | output | 8 | Message vector |
| msg_dest_o | output | 16 | Message destination |
| msg_dmode_o | output | 3 | Message delivery mode |

## Verification
The bench fires an edge pin while masked and then unmasks it; a design that latched the request would emit a stray message that the scoreboard rejects. It holds a level pin asserted across end-of-interrupt writes of a wrong and then the right vector, and shares one vector between two level pins, so a design that re-armed on any write, or only one of the sharers, shows a missing or extra message. Two pins fire together while the receiver stalls, so a design with reversed priority delivers in the wrong order and one that lets fields drift during the stall is caught by the hold check. Readback of the version word, the reset entries and writes to indices outside the table catch a wrong field layout or a decoder that aliases.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  localparam logic [1:0] WIN_INDEX = 2'd0;
  localparam logic [1:0] WIN_DATA  = 2'd1;
  localparam logic [1:0] WIN_EOI   = 2'd2;

  localparam logic [7:0] IDX_VERSION = 8'h01;
  localparam logic [7:0] IDX_TABLE   = 8'h10;

  typedef struct packed {
    logic [15:0] dest;
    logic        mask;
    logic        level;
    logic        act_low;
    logic [2:0]  dmode;
    logic [7:0]  vector;
  } redir_entry_t;

  localparam redir_entry_t ENTRY_RESET = '{dest: 16'h0, mask: 1'b1, level: 1'b0,
                                           act_low: 1'b0, dmode: 3'd0, vector: 8'h0};

  function automatic logic [31:0] low_word(input redir_entry_t e);
    return {15'b0, e.mask, e.level, 1'b0, e.act_low, 2'b0, e.dmode, e.vector};
  endfunction

  function automatic logic [31:0] high_word(input redir_entry_t e);
    return {e.dest, 16'h0};
  endfunction

endpackage

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irq_redir_pkg::*;
#(
  parameter int         NUM_PINS = 8,
  parameter logic [7:0] VERSION  = 8'h21
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [1:0]   addr_i,
  input  logic [31:0]  wdata_i,
  output logic [31:0]  rdata_o,
  output redir_entry_t entries_o [NUM_PINS],
  output logic         eoi_valid_o,
  output logic [7:0]   eoi_vector_o
);

  localparam int         SEL_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam logic [8:0] TBL_END = 9'(IDX_TABLE) + 9'(2 * NUM_PINS);
  localparam logic [7:0] TOP_PIN = 8'(NUM_PINS - 1);

  logic [7:0]       index_q, index_d;
  logic             in_table;
  logic [8:0]       rel;
  logic [SEL_W-1:0] sel;
  logic             hi_sel;
  logic             wr_data;
  redir_entry_t     cur;

  assign in_table = ({1'b0, index_q} >= 9'(IDX_TABLE)) && ({1'b0, index_q} < TBL_END);
  assign rel      = {1'b0, index_q} - 9'(IDX_TABLE);
  assign sel      = rel[SEL_W:1];
  assign hi_sel   = index_q[0];
  assign wr_data  = wr_en_i && (addr_i == WIN_DATA) && in_table;

  assign eoi_valid_o  = wr_en_i && (addr_i == WIN_EOI);
  assign eoi_vector_o = wdata_i[7:0];

  // index window
  always_comb begin
    index_d = index_q;
    if (wr_en_i && addr_i == WIN_INDEX) index_d = wdata_i[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) index_q <= 8'h0;
    else        index_q <= index_d;
  end

  // redirection entries, one register set per pin
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_entry
    redir_entry_t entry_q, entry_d;
    logic         hit;

    assign hit = wr_data && (sel == SEL_W'(g));

    always_comb begin
      entry_d = entry_q;
      if (hit) begin
        if (hi_sel) begin
          entry_d.dest = wdata_i[31:16];
        end else begin
          entry_d.vector  = wdata_i[7:0];
          entry_d.dmode   = wdata_i[10:8];
          entry_d.act_low = wdata_i[13];
          entry_d.level   = wdata_i[15];
          entry_d.mask    = wdata_i[16];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) entry_q <= ENTRY_RESET;
      else        entry_q <= entry_d;
    end

    assign entries_o[g] = entry_q;

    // R2: data writes outside the table leave every entry untouched
    assert_outside_write_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && addr_i == WIN_DATA && !in_table) |=> $stable(entry_q));
  end

  // read mux
  always_comb begin
    cur = ENTRY_RESET;
    for (int i = 0; i < NUM_PINS; i++) begin
      if (sel == SEL_W'(i)) cur = entries_o[i];
    end
  end

  always_comb begin
    rdata_o = 32'h0;
    unique case (addr_i)
      WIN_INDEX: rdata_o = {24'h0, index_q};
      WIN_DATA: begin
        if (index_q == IDX_VERSION)  rdata_o = {8'h0, TOP_PIN, 8'h0, VERSION};
        else if (in_table)           rdata_o = hi_sel ? high_word(cur) : low_word(cur);
        else                         rdata_o = 32'h0;
      end
      default: rdata_o = 32'h0;
    endcase
  end

endmodule

// File: rtl/irq_redir_pin.sv
module irq_redir_pin
  import irq_redir_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin_i,
  input  redir_entry_t entry_i,
  input  logic         eoi_valid_i,
  input  logic [7:0]   eoi_vector_i,
  input  logic         grant_i,
  output logic         req_o
);

  logic sync1_q, sync1_d;
  logic sync2_q, sync2_d;
  logic prev_q,  prev_d;
  logic pend_q,  pend_d;
  logic insvc_q, insvc_d;
  logic act, rise, eoi_hit;

  always_comb begin
    act     = sync2_q ^ entry_i.act_low;
    rise    = act & ~prev_q;
    eoi_hit = eoi_valid_i && (eoi_vector_i == entry_i.vector);

    sync1_d = pin_i;
    sync2_d = sync1_q;
    prev_d  = act;
    pend_d  = pend_q;
    insvc_d = insvc_q;

    if (entry_i.level) begin
      pend_d = 1'b0;
      if (eoi_hit) insvc_d = 1'b0;
      if (grant_i) insvc_d = 1'b1;
    end else begin
      insvc_d = 1'b0;
      if (grant_i)                  pend_d = 1'b0;
      if (rise && !entry_i.mask)    pend_d = 1'b1;
    end

    if (entry_i.level) req_o = act & ~entry_i.mask & ~insvc_q;
    else               req_o = pend_q & ~entry_i.mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
      pend_q  <= 1'b0;
      insvc_q <= 1'b0;
    end else begin
      sync1_q <= sync1_d;
      sync2_q <= sync2_d;
      prev_q  <= prev_d;
      pend_q  <= pend_d;
      insvc_q <= insvc_d;
    end
  end

  // R6: a masked edge pin never picks up a new pending request
  assert_masked_edge_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!entry_i.level && entry_i.mask && !pend_q) |=> !pend_q);

  // R7: a delivered level pin goes in service
  assert_level_enters_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_i && entry_i.level) |=> insvc_q);

  // R7: in-service level pin stays blocked until a matching EOI
  assert_level_waits_eoi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_i.level && insvc_q && !eoi_hit) |=> insvc_q);

endmodule

// File: rtl/irq_redir_arb.sv
module irq_redir_arb
  import irq_redir_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] req_i,
  input  redir_entry_t        entries_i [NUM_PINS],
  input  logic                ready_i,
  output logic                valid_o,
  output logic [7:0]          vector_o,
  output logic [15:0]         dest_o,
  output logic [2:0]          dmode_o,
  output logic [NUM_PINS-1:0] grant_o
);

  localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  logic             valid_q, valid_d;
  logic [PIN_W-1:0] pin_q, pin_d;
  logic [7:0]       vector_q, vector_d;
  logic [15:0]      dest_q, dest_d;
  logic [2:0]       dmode_q, dmode_d;
  logic [PIN_W-1:0] win;
  logic             found;
  logic             load;

  // lowest index wins: scan downward so the last hit is the smallest
  always_comb begin
    win   = '0;
    found = 1'b0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        win   = PIN_W'(i);
        found = 1'b1;
      end
    end
  end

  assign load = !valid_q && found;

  always_comb begin
    valid_d  = valid_q;
    pin_d    = pin_q;
    vector_d = vector_q;
    dest_d   = dest_q;
    dmode_d  = dmode_q;
    if (valid_q && ready_i) valid_d = 1'b0;
    if (load) begin
      valid_d  = 1'b1;
      pin_d    = win;
      vector_d = entries_i[win].vector;
      dest_d   = entries_i[win].dest;
      dmode_d  = entries_i[win].dmode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      pin_q    <= '0;
      vector_q <= 8'h0;
      dest_q   <= 16'h0;
      dmode_q  <= 3'd0;
    end else begin
      valid_q  <= valid_d;
      pin_q    <= pin_d;
      vector_q <= vector_d;
      dest_q   <= dest_d;
      dmode_q  <= dmode_d;
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_grant
    assign grant_o[g] = valid_q && ready_i && (pin_q == PIN_W'(g));
  end

  assign valid_o  = valid_q;
  assign vector_o = vector_q;
  assign dest_o   = dest_q;
  assign dmode_o  = dmode_q;

  // R10: a stalled message holds still
  assert_msg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready_i) |=> (valid_q && $stable(vector_q) && $stable(dest_q) && $stable(dmode_q)));

  // R9: pin 0 requesting into an idle output is the one captured
  assert_low_pin_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q && req_i[0]) |=> (valid_q && pin_q == '0));

endmodule

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
  import irq_redir_pkg::*;
#(
  parameter int         NUM_PINS = 8,
  parameter logic [7:0] VERSION  = 8'h21
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] irq_pins_i,
  input  logic                reg_wr_en_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic                msg_valid_o,
  input  logic                msg_ready_i,
  output logic [7:0]          msg_vector_o,
  output logic [15:0]         msg_dest_o,
  output logic [2:0]          msg_dmode_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  redir_entry_t        entries [NUM_PINS];
  logic                eoi_valid;
  logic [7:0]          eoi_vector;
  logic [NUM_PINS-1:0] req;
  logic [NUM_PINS-1:0] grant;

  irq_redir_regs #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_regs (
    .clk          (clk),
    .rst_n        (rst_sync_q),
    .wr_en_i      (reg_wr_en_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .rdata_o      (reg_rdata_o),
    .entries_o    (entries),
    .eoi_valid_o  (eoi_valid),
    .eoi_vector_o (eoi_vector)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    irq_redir_pin u_pin (
      .clk          (clk),
      .rst_n        (rst_sync_q),
      .pin_i        (irq_pins_i[g]),
      .entry_i      (entries[g]),
      .eoi_valid_i  (eoi_valid),
      .eoi_vector_i (eoi_vector),
      .grant_i      (grant[g]),
      .req_o        (req[g])
    );
  end

  irq_redir_arb #(.NUM_PINS(NUM_PINS)) u_arb (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .req_i     (req),
    .entries_i (entries),
    .ready_i   (msg_ready_i),
    .valid_o   (msg_valid_o),
    .vector_o  (msg_vector_o),
    .dest_o    (msg_dest_o),
    .dmode_o   (msg_dmode_o),
    .grant_o   (grant)
  );

endmodule

// File: tb/irq_redir_ctrl_bench.sv
`timescale 1ns/1ps
module irq_redir_ctrl_bench;

  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    addr = 2'd1;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          mvalid;
  logic          mready = 1'b1;
  logic [7:0]    mvec;
  logic [15:0]   mdest;
  logic [2:0]    mdm;

  int checks = 0;
  int errors = 0;

  logic [26:0] expq[$];
  string       tagq[$];

  always #4 clk = ~clk;

  irq_redir_ctrl #(.NUM_PINS(NP), .VERSION(8'h21)) u_irq_redir_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_pins_i(pins),
    .reg_wr_en_i(wr_en), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .msg_valid_o(mvalid), .msg_ready_i(mready),
    .msg_vector_o(mvec), .msg_dest_o(mdest), .msg_dmode_o(mdm)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 2'd1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
    addr = 2'd1;
  endtask

  task automatic rd_entry(input logic [7:0] idx, output logic [31:0] d);
    wr(2'd0, {24'h0, idx});
    rd(2'd1, d);
  endtask

  task automatic cfg(input int pin, input logic [7:0] vec, input logic [2:0] dm,
                     input logic pol, input logic lvl, input logic msk, input logic [15:0] dest);
    wr(2'd0, 32'(8'h11 + 2 * pin));
    wr(2'd1, {dest, 16'h0});
    wr(2'd0, 32'(8'h10 + 2 * pin));
    wr(2'd1, {15'b0, msk, lvl, 1'b0, pol, 2'b0, dm, vec});
  endtask

  task automatic push(input string tag, input logic [7:0] vec, input logic [15:0] dest,
                      input logic [2:0] dm);
    expq.push_back({vec, dest, dm});
    tagq.push_back(tag);
  endtask

  task automatic drain(input string tag);
    int n;
    n = 0;
    while (expq.size() != 0 && n < 80) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " all expected messages delivered"}, 32'(expq.size()), 32'd0);
  endtask

  task automatic quiet(input string tag, input int cyc);
    repeat (cyc) @(negedge clk);
    chk({tag, " no pending expectation"}, 32'(expq.size()), 32'd0);
  endtask

  // scoreboard monitor, samples 2 ns after the falling edge
  logic        p_valid = 1'b0, p_ready = 1'b0;
  logic [26:0] p_msg = '0;
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (p_valid && !p_ready) begin
          checks++;
          if (!mvalid || {mvec, mdest, mdm} !== p_msg) begin
            errors++;
            $display("FAIL R10 stalled message changed: actual %b/%h expected 1/%h",
                     mvalid, {mvec, mdest, mdm}, p_msg);
          end
        end
        if (mvalid && mready) begin
          checks++;
          if (expq.size() == 0) begin
            errors++;
            $display("FAIL R4/R6/R7/R11 unexpected message: actual %h expected none",
                     {mvec, mdest, mdm});
          end else begin
            logic [26:0] e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            if ({mvec, mdest, mdm} !== e) begin
              errors++;
              $display("FAIL %s message: actual %h expected %h", t, {mvec, mdest, mdm}, e);
            end
          end
        end
        p_valid = mvalid;
        p_ready = mready;
        p_msg   = {mvec, mdest, mdm};
      end
    end
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 reset state
    chk("R3 no message after reset", 32'(mvalid), 32'd0);
    rd_entry(8'h10, d); chk("R3 pin0 low word reset", d, 32'h0001_0000);
    rd_entry(8'h1E, d); chk("R3 pin7 low word reset", d, 32'h0001_0000);
    rd_entry(8'h1F, d); chk("R3 pin7 high word reset", d, 32'h0);

    // R1 version, R2 window decode
    rd_entry(8'h01, d); chk("R1 version word", d, 32'h0007_0021);
    rd(2'd0, d);        chk("R2 index readback", d, 32'h01);
    rd_entry(8'h05, d); chk("R2 unmapped index reads zero", d, 32'h0);
    wr(2'd0, 32'h30); wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d);        chk("R2 write outside table ignored", d, 32'h0);
    rd_entry(8'h10, d); chk("R2 pin0 untouched by outside write", d, 32'h0001_0000);

    // R4 edge delivery and field layout
    cfg(0, 8'h41, 3'd1, 1'b0, 1'b0, 1'b0, 16'h1234);
    rd_entry(8'h10, d); chk("R2 pin0 low word layout", d, 32'h0000_0141);
    rd_entry(8'h11, d); chk("R2 pin0 high word layout", d, 32'h1234_0000);
    push("R4 edge pin0", 8'h41, 16'h1234, 3'd1);
    pins[0] = 1'b1;
    drain("R4 edge pin0");
    quiet("R4 held edge gives one message", 16);
    pins[0] = 1'b0;
    repeat (4) @(negedge clk);
    push("R4 second edge pin0", 8'h41, 16'h1234, 3'd1);
    pins[0] = 1'b1;
    drain("R4 second edge pin0");
    pins[0] = 1'b0;

    // R5 active-low polarity
    pins[1] = 1'b1;
    repeat (4) @(negedge clk);
    cfg(1, 8'h52, 3'd5, 1'b1, 1'b0, 1'b0, 16'h0201);
    quiet("R5 high input inactive", 8);
    push("R5 falling input fires", 8'h52, 16'h0201, 3'd5);
    pins[1] = 1'b0;
    drain("R5 falling input fires");
    pins[1] = 1'b1;
    quiet("R5 rising input silent", 10);

    // R6 masked edge dropped
    cfg(2, 8'h63, 3'd0, 1'b0, 1'b0, 1'b1, 16'h0302);
    pins[2] = 1'b1; repeat (4) @(negedge clk); pins[2] = 1'b0;
    repeat (4) @(negedge clk);
    wr(2'd0, 32'h14); wr(2'd1, 32'h0000_0063);
    quiet("R6 unmask after masked edge", 12);
    push("R6 edge after unmask", 8'h63, 16'h0302, 3'd0);
    pins[2] = 1'b1; repeat (4) @(negedge clk); pins[2] = 1'b0;
    drain("R6 edge after unmask");

    // R7 level with EOI
    cfg(3, 8'h70, 3'd2, 1'b0, 1'b1, 1'b0, 16'h0102);
    push("R7 level first", 8'h70, 16'h0102, 3'd2);
    pins[3] = 1'b1;
    drain("R7 level first");
    quiet("R7 blocked before EOI", 20);
    wr(2'd2, 32'h71);
    quiet("R8 wrong vector EOI", 12);
    push("R7 level after EOI", 8'h70, 16'h0102, 3'd2);
    wr(2'd2, 32'h70);
    drain("R7 level after EOI");
    pins[3] = 1'b0;
    repeat (4) @(negedge clk);
    wr(2'd2, 32'h70);
    quiet("R7 EOI with input idle", 12);

    // R8 shared vector
    cfg(4, 8'h88, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0404);
    cfg(5, 8'h88, 3'd0, 1'b0, 1'b1, 1'b0, 16'h0505);
    push("R8 shared pin4", 8'h88, 16'h0404, 3'd0);
    push("R8 shared pin5", 8'h88, 16'h0505, 3'd0);
    pins[5:4] = 2'b11;
    drain("R8 shared first round");
    quiet("R8 both blocked", 10);
    push("R8 rearm pin4", 8'h88, 16'h0404, 3'd0);
    push("R8 rearm pin5", 8'h88, 16'h0505, 3'd0);
    wr(2'd2, 32'h88);
    drain("R8 single EOI rearms both");
    pins[5:4] = 2'b00;
    repeat (4) @(negedge clk);
    wr(2'd2, 32'h88);
    quiet("R8 idle after EOI", 8);

    // R9 priority, R10 hold under stall
    cfg(6, 8'h96, 3'd3, 1'b0, 1'b0, 1'b0, 16'h0606);
    mready = 1'b0;
    push("R9 lower pin first", 8'h63, 16'h0302, 3'd0);
    push("R9 higher pin second", 8'h96, 16'h0606, 3'd3);
    pins[6] = 1'b1; pins[2] = 1'b1;
    repeat (12) @(negedge clk);
    chk("R10 message offered under stall", 32'(mvalid), 32'd1);
    chk("R9 stalled message is pin2", 32'(mvec), 32'h63);
    mready = 1'b1;
    drain("R9 both delivered");
    pins[6] = 1'b0; pins[2] = 1'b0;

    // R11 masked level
    cfg(7, 8'hA7, 3'd4, 1'b0, 1'b1, 1'b1, 16'h0707);
    pins[7] = 1'b1;
    quiet("R11 masked level silent", 12);
    push("R11 unmask active level", 8'hA7, 16'h0707, 3'd4);
    wr(2'd0, 32'h1E); wr(2'd1, 32'h0000_84A7);
    drain("R11 unmask active level");
    pins[7] = 1'b0;
    repeat (4) @(negedge clk);
    wr(2'd2, 32'hA7);
    quiet("R11 idle after EOI", 10);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule